// File: doc/BRIEF.md
# Timing Command Monitor with Per-Code Histogram

This block observes a stream of broadcast timing commands that arrive already decoded as 4-bit codes. Each code is qualified by a one-cycle strobe. The block records the most recent code, and it keeps a separate 16-bit occurrence count for each of the sixteen possible code values. A 16-bit counter counts clock cycles of the timing domain while the external run controller reports an active run. The last command, the sixteen counts and the clock count can all be read through a simple register read port.

When the enable input is high, two chosen command codes become one-cycle run start and run stop requests for the run controller. Code 0x1 requests start and code 0x2 requests stop. A soft reset clears the statistics, which are the histogram and the clock count, but it keeps the record of the last command. The asynchronous hard reset clears everything.

Top module: `cmd_monitor`

## Requirements
- R1: A read of address 0x18 returns the code of the most recent strobed command in bits 3:0, and bits 15:4 are zero.
- R2: A read of address 0x20+n (n = 0..15) returns how many strobed commands carried code n. Each strobed command adds exactly one to its own counter and leaves the other fifteen unchanged.
- R3: A histogram counter that has reached 0xFFFF stays at 0xFFFF when further commands with its code arrive.
- R4: When the enable input is high, a strobed code 0x1 produces a start request that is high for exactly the next cycle, and a strobed code 0x2 produces a stop request in the same way. The two requests are never high together.
- R5: When the enable input is low, no strobed command produces a start or stop request.
- R6: A read of address 0x3D returns the number of clock cycles during which the run-active input was high since the last reset. The count does not change while run-active is low.
- R7: A soft reset pulse sets all sixteen histogram counters and the clock counter to zero but leaves the last-command value unchanged. A command strobed in the same cycle as the soft reset is not counted, but it is still recorded as the last command.
- R8: While the hard reset is asserted, every counter and the last-command value are zero and both requests are low.
- R9: The read data and the read-valid flag appear in the cycle after a read strobe. The read-valid flag is low in every other cycle. An address outside 0x18, 0x20..0x2F and 0x3D reads as zero.
- R10: A command code presented without its strobe changes no counter and no last-command value, and it produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing-domain clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| cmdValid | input | 1 | Strobe that qualifies cmdCode |
| cmdCode | input | 4 | Decoded timing command code |
| cmdRunEnable | input | 1 | Control bit that allows commands to request start and stop |
| softReset | input | 1 | Clears the histogram and the clock counter |
| runActive | input | 1 | High while the run controller is in the started state |
| regRdEn | input | 1 | Read strobe |
| regAddr | input | 8 | Read address |
| regRdData | output | 16 | Read data, registered |
| regRdValid | output | 1 | High for one cycle when regRdData carries a result |
| runStartReq | output | 1 | One-cycle run start request |
| runStopReq | output | 1 | One-cycle run stop request |

## Verification
The assertions check the following on every cycle: the request pulses follow the enabled start and stop codes, the requests stay silent when the enable is low or no strobe is present, read-valid tracks the read strobe, and unmapped addresses and the upper last-command bits read as zero. The bench scenarios cover the rest, because these behaviours need a history: histogram counts over mixed code patterns, saturation after more than 65535 hits, the clock count over a known window of run-active cycles, and the selective clearing by the soft reset against the hard reset.

// File: rtl/cmd_monitor_pkg.sv
package cmd_monitor_pkg;
  // Width of a decoded timing command; fixed by the broadcast protocol.
  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic              histClr;
    logic              histInc;
    logic [CODE_W-1:0] histSel;
    logic              lastLoad;
    logic [CODE_W-1:0] lastVal;
    logic              clkClr;
    logic              clkInc;
  } dpCtrl_t;
endpackage

// File: rtl/cmd_monitor_ctrl.sv
module cmd_monitor_ctrl
  import cmd_monitor_pkg::*;
#(
  parameter logic [CODE_W-1:0] START_CODE = 4'h1,
  parameter logic [CODE_W-1:0] STOP_CODE  = 4'h2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              cmdRunEnable,
  input  logic              softReset,
  input  logic              runActive,
  output dpCtrl_t           dpCtrl,
  output logic              runStartReq,
  output logic              runStopReq
);

  logic startHit;
  logic stopHit;

  always_comb begin
    dpCtrl          = '0;
    // Soft reset wins over a same-cycle increment; last command still loads.
    dpCtrl.histClr  = softReset;
    dpCtrl.histInc  = cmdValid && !softReset;
    dpCtrl.histSel  = cmdCode;
    dpCtrl.lastLoad = cmdValid;
    dpCtrl.lastVal  = cmdCode;
    dpCtrl.clkClr   = softReset;
    dpCtrl.clkInc   = runActive && !softReset;
  end

  assign startHit = cmdValid && cmdRunEnable && (cmdCode == START_CODE);
  assign stopHit  = cmdValid && cmdRunEnable && (cmdCode == STOP_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runStartReq <= 1'b0;
      runStopReq  <= 1'b0;
    end else begin
      runStartReq <= startHit;
      runStopReq  <= stopHit;
    end
  end

endmodule

// File: rtl/cmd_monitor_dp.sv
module cmd_monitor_dp
  import cmd_monitor_pkg::*;
#(
  parameter int                CNT_W     = 16,
  parameter int                LAST_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] HIST_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 8'h3D
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  histCnt [NUM_CODES];
  logic [LAST_W-1:0] lastCmd;
  logic [CNT_W-1:0]  clkCnt;
  logic [ADDR_W-1:0] histOff;
  logic              inHist;
  logic [DATA_W-1:0] rdMux;

  // One saturating counter per command code.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_hist
    logic hit;
    assign hit = dpCtrl.histInc && (dpCtrl.histSel == CODE_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            histCnt[g] <= '0;
      else if (dpCtrl.histClr)              histCnt[g] <= '0;
      else if (hit && histCnt[g] != CNT_MAX) histCnt[g] <= histCnt[g] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lastCmd <= '0;
    else if (dpCtrl.lastLoad) lastCmd <= LAST_W'(dpCtrl.lastVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              clkCnt <= '0;
    else if (dpCtrl.clkClr) clkCnt <= '0;
    else if (dpCtrl.clkInc) clkCnt <= clkCnt + 1'b1;
  end

  // Offset wraps below the base, so one compare covers both bounds.
  assign histOff = regAddr - HIST_BASE;
  assign inHist  = histOff < ADDR_W'(NUM_CODES);

  always_comb begin
    rdMux = '0;
    if (regAddr == LAST_ADDR)     rdMux = DATA_W'(lastCmd);
    else if (regAddr == CLK_ADDR) rdMux = DATA_W'(clkCnt);
    else if (inHist)              rdMux = DATA_W'(histCnt[histOff[CODE_W-1:0]]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= regRdEn;
      regRdData  <= regRdEn ? rdMux : '0;
    end
  end

endmodule

// File: rtl/cmd_monitor.sv
module cmd_monitor
  import cmd_monitor_pkg::*;
#(
  parameter int                CNT_W      = 16,
  parameter int                LAST_W     = 8,
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] LAST_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] HIST_BASE  = 8'h20,
  parameter logic [ADDR_W-1:0] CLK_ADDR   = 8'h3D,
  parameter logic [CODE_W-1:0] START_CODE = 4'h1,
  parameter logic [CODE_W-1:0] STOP_CODE  = 4'h2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              cmdRunEnable,
  input  logic              softReset,
  input  logic              runActive,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic              runStartReq,
  output logic              runStopReq
);

  dpCtrl_t dpCtrl;

  cmd_monitor_ctrl #(
    .START_CODE(START_CODE),
    .STOP_CODE (STOP_CODE)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdCode     (cmdCode),
    .cmdRunEnable(cmdRunEnable),
    .softReset   (softReset),
    .runActive   (runActive),
    .dpCtrl      (dpCtrl),
    .runStartReq (runStartReq),
    .runStopReq  (runStopReq)
  );

  cmd_monitor_dp #(
    .CNT_W    (CNT_W),
    .LAST_W   (LAST_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LAST_ADDR(LAST_ADDR),
    .HIST_BASE(HIST_BASE),
    .CLK_ADDR (CLK_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .regRdValid(regRdValid)
  );

endmodule

// File: rtl/cmd_monitor_chk.sv
module cmd_monitor_chk
  import cmd_monitor_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] LAST_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] HIST_BASE  = 8'h20,
  parameter logic [ADDR_W-1:0] CLK_ADDR   = 8'h3D,
  parameter logic [CODE_W-1:0] START_CODE = 4'h1,
  parameter logic [CODE_W-1:0] STOP_CODE  = 4'h2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [CODE_W-1:0] cmdCode,
  input logic              cmdRunEnable,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              regRdValid,
  input logic              runStartReq,
  input logic              runStopReq
);

  logic unmapped;
  assign unmapped = (regAddr != LAST_ADDR) && (regAddr != CLK_ADDR) &&
                    !((regAddr >= HIST_BASE) &&
                      ({1'b0, regAddr} < {1'b0, HIST_BASE} + (ADDR_W+1)'(NUM_CODES)));

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdRunEnable && cmdCode == START_CODE) |=> runStartReq); // R4
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdRunEnable && cmdCode == STOP_CODE) |=> runStopReq); // R4
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(runStartReq && runStopReq)); // R4
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !cmdRunEnable |=> !runStartReq && !runStopReq); // R5
  AST_NO_REQ_UNSTROBED: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !runStartReq && !runStopReq); // R10
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && unmapped) |=> regRdData == '0); // R9
  AST_LAST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == LAST_ADDR) |=> regRdData[DATA_W-1:CODE_W] == '0); // R1

endmodule

bind cmd_monitor cmd_monitor_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LAST_ADDR (LAST_ADDR),
  .HIST_BASE (HIST_BASE),
  .CLK_ADDR  (CLK_ADDR),
  .START_CODE(START_CODE),
  .STOP_CODE (STOP_CODE)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdCode     (cmdCode),
  .cmdRunEnable(cmdRunEnable),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .regRdValid  (regRdValid),
  .runStartReq (runStartReq),
  .runStopReq  (runStopReq)
);

// File: tb/cmd_monitor_tb.sv
module cmd_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdCode = '0;
  logic        cmdRunEnable = 1'b0;
  logic        softReset = 1'b0;
  logic        runActive = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regRdData;
  logic        regRdValid;
  logic        runStartReq;
  logic        runStopReq;

  int checks = 0;
  int errors = 0;
  int histModel [16];
  logic [3:0] lastModel;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_monitor u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdRunEnable(cmdRunEnable), .softReset(softReset), .runActive(runActive),
    .regRdEn(regRdEn), .regAddr(regAddr), .regRdData(regRdData),
    .regRdValid(regRdValid), .runStartReq(runStartReq), .runStopReq(runStopReq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 16; i++) histModel[i] = 0;
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [15:0] data);
    @(negedge clk);
    regRdEn = 1'b1;
    regAddr = addr;
    @(negedge clk);
    regRdEn = 1'b0;
    data = regRdData;
    check("R9 read valid", {15'd0, regRdValid}, 16'd1);
  endtask

  task automatic sendBurst(input logic [3:0] code, input int n);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = code;
    repeat (n) @(negedge clk);
    cmdValid = 1'b0;
    lastModel = code;
    histModel[code] = (histModel[code] + n > 65535) ? 65535 : histModel[code] + n;
  endtask

  task automatic checkAllHist(input string req);
    logic [15:0] d;
    for (int i = 0; i < 16; i++) begin
      readReg(8'h20 + 8'(i), d);
      check(req, d, 16'(histModel[i]));
    end
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 start low in reset", {15'd0, runStartReq}, 16'd0);
    check("R8 stop low in reset", {15'd0, runStopReq}, 16'd0);
    rstN = 1'b1;
    clearModel();
    lastModel = '0;
  endtask

  task automatic testReset();
    logic [15:0] d;
    readReg(8'h18, d); check("R8 last after reset", d, 16'h0);
    readReg(8'h3D, d); check("R8 clock count after reset", d, 16'h0);
    checkAllHist("R8 histogram after reset");
  endtask

  task automatic testHistogram();
    logic [15:0] d;
    sendBurst(4'h3, 5);
    sendBurst(4'hF, 2);
    sendBurst(4'h0, 1);
    sendBurst(4'h3, 1);
    for (int i = 0; i < 16; i++) sendBurst(4'(i), 1);
    checkAllHist("R2 histogram counts");
    readReg(8'h18, d); check("R1 last command", d, {12'd0, lastModel});
    sendBurst(4'hA, 1);
    readReg(8'h18, d); check("R1 last command 0xA", d, 16'h000A);
  endtask

  task automatic testNoStrobe();
    logic [15:0] d;
    cmdRunEnable = 1'b1;
    @(negedge clk);
    cmdCode = 4'h1;
    repeat (2) @(negedge clk);
    check("R10 no request without strobe", {15'd0, runStartReq}, 16'd0);
    cmdCode = 4'h7;
    repeat (4) @(negedge clk);
    cmdRunEnable = 1'b0;
    readReg(8'h18, d); check("R10 last unchanged", d, {12'd0, lastModel});
    checkAllHist("R10 histogram unchanged");
  endtask

  task automatic testRunRequests(input logic enable);
    string req;
    req = enable ? "R4" : "R5";
    cmdRunEnable = enable;
    sendBurst(4'h1, 1);
    check({req, " start request"}, {15'd0, runStartReq}, 16'(enable));
    check({req, " no stop on start"}, {15'd0, runStopReq}, 16'd0);
    @(negedge clk);
    check({req, " start one cycle"}, {15'd0, runStartReq}, 16'd0);
    sendBurst(4'h2, 1);
    check({req, " stop request"}, {15'd0, runStopReq}, 16'(enable));
    check({req, " no start on stop"}, {15'd0, runStartReq}, 16'd0);
    @(negedge clk);
    check({req, " stop one cycle"}, {15'd0, runStopReq}, 16'd0);
    cmdRunEnable = 1'b0;
  endtask

  task automatic testClockCount();
    logic [15:0] d;
    @(negedge clk); softReset = 1'b1;
    @(negedge clk); softReset = 1'b0;
    clearModel();
    runActive = 1'b1;
    repeat (37) @(negedge clk);
    runActive = 1'b0;
    readReg(8'h3D, d); check("R6 clock count while run", d, 16'd37);
    repeat (10) @(negedge clk);
    readReg(8'h3D, d); check("R6 clock count holds when idle", d, 16'd37);
    runActive = 1'b1;
    repeat (5) @(negedge clk);
    runActive = 1'b0;
    readReg(8'h3D, d); check("R6 clock count resumes", d, 16'd42);
  endtask

  task automatic testSoftReset();
    logic [15:0] d;
    sendBurst(4'h5, 3);
    sendBurst(4'h9, 2);
    runActive = 1'b1;
    repeat (4) @(negedge clk);
    runActive = 1'b0;
    @(negedge clk);
    softReset = 1'b1;
    cmdValid  = 1'b1;
    cmdCode   = 4'hC;
    @(negedge clk);
    softReset = 1'b0;
    cmdValid  = 1'b0;
    clearModel();
    lastModel = 4'hC;
    checkAllHist("R7 histogram cleared");
    readReg(8'h3D, d); check("R7 clock count cleared", d, 16'd0);
    readReg(8'h18, d); check("R7 last command kept", d, 16'h000C);
  endtask

  task automatic testSaturation();
    logic [15:0] d;
    sendBurst(4'h6, 65534);
    readReg(8'h26, d); check("R3 below limit", d, 16'hFFFE);
    sendBurst(4'h6, 1);
    readReg(8'h26, d); check("R3 at limit", d, 16'hFFFF);
    sendBurst(4'h6, 4);
    readReg(8'h26, d); check("R3 saturated", d, 16'hFFFF);
    readReg(8'h27, d); check("R3 neighbour untouched", d, 16'(histModel[7]));
  endtask

  task automatic testUnmapped();
    logic [15:0] d;
    readReg(8'h1F, d); check("R9 unmapped 0x1F", d, 16'h0);
    readReg(8'h30, d); check("R9 unmapped 0x30", d, 16'h0);
    readReg(8'hFF, d); check("R9 unmapped 0xFF", d, 16'h0);
    @(negedge clk);
    check("R9 valid low when idle", {15'd0, regRdValid}, 16'd0);
  endtask

  task automatic testHardReset();
    sendBurst(4'h4, 3);
    runActive = 1'b1;
    repeat (3) @(negedge clk);
    runActive = 1'b0;
    hardReset();
    testReset();
  endtask

  initial begin
    clearModel();
    lastModel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHistogram();
    testNoStrobe();
    testRunRequests(1'b1);
    testRunRequests(1'b0);
    testClockCount();
    testSoftReset();
    testUnmapped();
    testSaturation();
    testHardReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule